// File: doc/BRIEF.md
# Address Map Decoder with Low-Window Selection

This block sits between a processor bus and the memories of a controller with a 24-bit physical address space. Each bus address is decoded into one of four regions: program ROM, data RAM, special-function memory (SFR) and the I/O area. The block reports which region is hit, the byte offset inside that region, and whether the region has a 16-bit or a 32-bit data path. It also tells the bus when the access may complete, holding `ready_o` low for a configurable number of cycles on the slow 16-bit regions.

The low window starting at address 0 is shared. A 2-bit mapping register decides what answers there. ROM can be relocated, so that it answers only at the bottom of the map. RAM or SFR can be duplicated, so that each answers both at the bottom and at its normal window. A strap input chooses the value this register takes at reset, so the first instruction fetches find either ROM or SFR at address 0. Software may rewrite the register later.

Top module: `memmap_decoder`

## Requirements
- R1: While `rst` is high the mapping register loads 2'b10 (SFR duplicated low) if `boot_sfr_i` is 1 and 2'b00 (ROM relocated low) otherwise. The value is visible on `mode_o` after the first clock edge in reset.
- R2: A clock edge with `mode_we_i` high loads `mode_wdata_i` into the mapping register when the value is 2'b00, 2'b01 or 2'b10. The value 2'b11 is ignored and the old mode is kept. The register does not change without `mode_we_i`.
- R3: In mode 2'b00, addresses 0x000000–0x7FFFFF select ROM with offset equal to the address. The ROM home addresses above that window, 0x800000–0x9FFFFF, report a miss.
- R4: In modes 2'b01 and 2'b10, ROM answers at 0x200000–0x9FFFFF with offset equal to the address minus 0x200000.
- R5: RAM answers at 0xC00000–0xDFFFFF in every mode, with offset equal to the address minus 0xC00000. In mode 2'b01 it also answers at 0x000000–0x1FFFFF, with offset equal to the address.
- R6: SFR answers at 0xF00000–0xF7FFFF in every mode, with offset equal to the address minus 0xF00000. In mode 2'b10 it also answers at 0x000000–0x07FFFF, with offset equal to the address.
- R7: I/O answers at 0xF80000–0xFFFFFF in every mode, with offset equal to the address minus 0xF80000.
- R8: `sel_o` bit 0 is ROM, bit 1 RAM, bit 2 SFR and bit 3 I/O. At most one bit is set. An address outside every active window sets `miss_o`, clears `sel_o` and drives offset 0.
- R9: `wide_o` is 1 for RAM and SFR (32-bit regions) and 0 for ROM, I/O and a miss.
- R10: A request (`req_i` held high with a stable address) that selects ROM or I/O, where the wait count N from `rom_wait_i` or `io_wait_i` is greater than 0, keeps `ready_o` low for N cycles starting with the first request cycle. `ready_o` is high in cycle N. With N = 0, `ready_o` is high in the first cycle.
- R11: A request that selects RAM or SFR, or that misses, gets `ready_o` high in its first cycle. `ready_o` is never high without `req_i`.
- R12: Dropping `req_i` during a wait abandons it. The next request counts its full wait again from its own first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_sfr_i | input | 1 | Strap: 1 selects SFR-duplicated mode at reset |
| mode_we_i | input | 1 | Write strobe for the mapping register |
| mode_wdata_i | input | 2 | New mapping mode |
| mode_o | output | 2 | Current mapping mode |
| addr_i | input | 24 | Bus address |
| req_i | input | 1 | Access request, held until ready |
| rom_wait_i | input | WAIT_W | Wait cycles for ROM accesses |
| io_wait_i | input | WAIT_W | Wait cycles for I/O accesses |
| sel_o | output | 4 | Region select, one-hot or zero |
| miss_o | output | 1 | Address hits no active window |
| offset_o | output | 24 | Offset within the selected region |
| wide_o | output | 1 | Selected region is 32 bits wide |
| ready_o | output | 1 | Access may complete this cycle |

## Verification
A wrong mapping register is seen on the next cycle as a changed `mode_o`. It is seen at once, without any clock, as wrong selects and offsets for addresses in the low window. A stuck or misloaded wait counter shows up as `ready_o` rising one or more cycles early or late in a slow access. An abort that leaves the sequencer busy shows up in the first cycle of the following request. A decode fault makes two select bits rise together or leaves `miss_o` set beside a select, within the same cycle as the address.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int ADDR_W = 24;
    localparam int NREG   = 4;

    localparam int IDX_ROM = 0;
    localparam int IDX_RAM = 1;
    localparam int IDX_SFR = 2;
    localparam int IDX_IO  = 3;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        MAP_ROM_LOW  = 2'b00,
        MAP_RAM_BOTH = 2'b01,
        MAP_SFR_BOTH = 2'b10
    } map_mode_e;

    localparam addr_t ROM_HOME = 24'h200000;
    localparam addr_t ROM_SPAN = 24'h800000;
    localparam addr_t RAM_HOME = 24'hC00000;
    localparam addr_t RAM_SPAN = 24'h200000;
    localparam addr_t SFR_HOME = 24'hF00000;
    localparam addr_t SFR_SPAN = 24'h080000;
    localparam addr_t IO_HOME  = 24'hF80000;
    localparam addr_t IO_SPAN  = 24'h080000;

    // 1 marks a 32-bit region
    localparam logic [NREG-1:0] WIDE_MASK = 4'b0110;

    typedef struct packed {
        logic [NREG-1:0] sel;
        logic            miss;
        addr_t           offset;
        logic            wide;
    } dec_t;

    function automatic logic in_win(addr_t a, addr_t base, addr_t span);
        return (a >= base) && ((a - base) < span);
    endfunction

    function automatic logic mode_legal(logic [1:0] m);
        return m != 2'b11;
    endfunction

endpackage

// File: rtl/memmap_mode_reg.sv
module memmap_mode_reg
    import memmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       boot_sfr,
    input  logic       we,
    input  logic [1:0] wdata,
    output map_mode_e  mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= boot_sfr ? MAP_SFR_BOTH : MAP_ROM_LOW;
        end else if (we && mode_legal(wdata)) begin
            mode <= map_mode_e'(wdata);
        end
    end

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b11); // R2
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(we && wdata != 2'b11) |=> $stable(mode)); // R2

endmodule

// File: rtl/memmap_decode.sv
module memmap_decode
    import memmap_pkg::*;
(
    input  map_mode_e mode,
    input  addr_t     addr,
    output dec_t      dec
);

    logic [NREG-1:0] hit;
    addr_t           base_a [NREG];

    always_comb begin
        // ROM: home window unless relocated to the bottom
        if (mode == MAP_ROM_LOW) begin
            hit[IDX_ROM]    = addr < ROM_SPAN;
            base_a[IDX_ROM] = '0;
        end else begin
            hit[IDX_ROM]    = in_win(addr, ROM_HOME, ROM_SPAN);
            base_a[IDX_ROM] = ROM_HOME;
        end
        // RAM: home always, bottom copy in its mode
        hit[IDX_RAM]    = in_win(addr, RAM_HOME, RAM_SPAN) ||
                          ((mode == MAP_RAM_BOTH) && (addr < RAM_SPAN));
        base_a[IDX_RAM] = (addr < RAM_SPAN) ? '0 : RAM_HOME;
        // SFR: home always, bottom copy in its mode
        hit[IDX_SFR]    = in_win(addr, SFR_HOME, SFR_SPAN) ||
                          ((mode == MAP_SFR_BOTH) && (addr < SFR_SPAN));
        base_a[IDX_SFR] = (addr < SFR_SPAN) ? '0 : SFR_HOME;
        // I/O: fixed
        hit[IDX_IO]     = in_win(addr, IO_HOME, IO_SPAN);
        base_a[IDX_IO]  = IO_HOME;
    end

    always_comb begin
        dec        = '0;
        dec.miss   = 1'b1;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                dec.sel[i] = 1'b1;
                dec.miss   = 1'b0;
                dec.offset = addr - base_a[i];
                dec.wide   = WIDE_MASK[i];
            end
        end
    end

endmodule

// File: rtl/memmap_wait_seq.sv
module memmap_wait_seq #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [WAIT_W-1:0] wait_n,
    output logic              ready
);

    logic              busy;
    logic [WAIT_W-1:0] cnt;

    always_comb begin
        if (busy) ready = req && (cnt == '0);
        else      ready = req && (wait_n == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (req && wait_n != '0) begin
                busy <= 1'b1;
                cnt  <= wait_n - 1'b1;
            end
        end else if (!req || cnt == '0) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        ready |-> req); // R11
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (busy && !req) |=> !busy); // R12

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_sfr_i,
    input  logic              mode_we_i,
    input  logic [1:0]        mode_wdata_i,
    output logic [1:0]        mode_o,
    input  logic [23:0]       addr_i,
    input  logic              req_i,
    input  logic [WAIT_W-1:0] rom_wait_i,
    input  logic [WAIT_W-1:0] io_wait_i,
    output logic [3:0]        sel_o,
    output logic              miss_o,
    output logic [23:0]       offset_o,
    output logic              wide_o,
    output logic              ready_o
);

    map_mode_e         mode;
    dec_t              dec;
    logic [WAIT_W-1:0] wait_n;

    memmap_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .boot_sfr (boot_sfr_i),
        .we       (mode_we_i),
        .wdata    (mode_wdata_i),
        .mode     (mode)
    );

    memmap_decode u_dec (
        .mode (mode),
        .addr (addr_i),
        .dec  (dec)
    );

    always_comb begin
        if (dec.sel[IDX_ROM])     wait_n = rom_wait_i;
        else if (dec.sel[IDX_IO]) wait_n = io_wait_i;
        else                      wait_n = '0;
    end

    memmap_wait_seq #(.WAIT_W(WAIT_W)) u_wait (
        .clk    (clk),
        .rst    (rst),
        .req    (req_i),
        .wait_n (wait_n),
        .ready  (ready_o)
    );

    assign mode_o   = mode;
    assign sel_o    = dec.sel;
    assign miss_o   = dec.miss;
    assign offset_o = dec.offset;
    assign wide_o   = dec.wide;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o)); // R8
    AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        miss_o |-> (sel_o == '0 && offset_o == '0 && !wide_o)); // R8
    AST_RELOC_HOME_GONE: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b00 && addr_i >= 24'h800000 && addr_i <= 24'h9FFFFF) |-> miss_o); // R3
    AST_FAST_READY: assert property (@(posedge clk) disable iff (rst)
        ($rose(req_i) && (sel_o[1] || sel_o[2] || miss_o)) |-> ready_o); // R11
    AST_SLOW_START: assert property (@(posedge clk) disable iff (rst)
        ($rose(req_i) && sel_o[0] && rom_wait_i != '0) |-> !ready_o); // R10

endmodule

// File: tb/memmap_decoder_tb_top.sv
module memmap_decoder_tb_top;

    localparam int WAIT_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              boot_sfr_i = 1'b0;
    logic              mode_we_i = 1'b0;
    logic [1:0]        mode_wdata_i = 2'b00;
    logic [1:0]        mode_o;
    logic [23:0]       addr_i = '0;
    logic              req_i = 1'b0;
    logic [WAIT_W-1:0] rom_wait_i = '0;
    logic [WAIT_W-1:0] io_wait_i = '0;
    logic [3:0]        sel_o;
    logic              miss_o;
    logic [23:0]       offset_o;
    logic              wide_o;
    logic              ready_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    memmap_decoder #(.WAIT_W(WAIT_W)) dut_i (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(logic strap);
        @(negedge clk);
        boot_sfr_i = strap;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        mode_we_i = 1'b1;
        mode_wdata_i = m;
        @(negedge clk);
        mode_we_i = 1'b0;
        #5;
    endtask

    task automatic chk_dec(string tag, logic [23:0] a, logic [3:0] esel,
                           logic [23:0] eoff, logic ewide);
        @(negedge clk);
        addr_i = a;
        #5;
        chk({tag, " sel"}, 32'(sel_o), 32'(esel));
        chk({tag, " miss"}, 32'(miss_o), 32'(esel == 4'b0));
        chk({tag, " off"}, 32'(offset_o), 32'(eoff));
        chk({tag, " R9 wide"}, 32'(wide_o), 32'(ewide));
    endtask

    // request held until ready; expect n low cycles then ready
    task automatic run_req(string tag, logic [23:0] a, logic [3:0] rw,
                           logic [3:0] iw, int n);
        @(negedge clk);
        addr_i = a; rom_wait_i = rw; io_wait_i = iw; req_i = 1'b1;
        for (int i = 0; i <= n; i++) begin
            #5;
            chk({tag, " ready"}, 32'(ready_o), 32'(i == n));
            if (i < n) @(negedge clk);
        end
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        chk("R1 strap0 mode", 32'(mode_o), 32'h0);
        chk("R11 idle ready", 32'(ready_o), 32'h0);
        do_reset(1'b1);
        chk("R1 strap1 mode", 32'(mode_o), 32'h2);
    endtask

    task automatic t_mode_write;
        set_mode(2'b01);
        chk("R2 write 01", 32'(mode_o), 32'h1);
        set_mode(2'b11);
        chk("R2 write 11 ignored", 32'(mode_o), 32'h1);
        repeat (3) @(negedge clk);
        #5;
        chk("R2 hold without we", 32'(mode_o), 32'h1);
        set_mode(2'b10);
        chk("R2 write 10", 32'(mode_o), 32'h2);
        set_mode(2'b00);
        chk("R2 write 00", 32'(mode_o), 32'h0);
    endtask

    task automatic t_rom_low;
        set_mode(2'b00);
        chk_dec("R3 rom low 0", 24'h000000, 4'b0001, 24'h000000, 1'b0);
        chk_dec("R3 rom low top", 24'h7FFFFE, 4'b0001, 24'h7FFFFE, 1'b0);
        chk_dec("R3 rom home gone", 24'h800000, 4'b0000, 24'h0, 1'b0);
        chk_dec("R3 rom home end gone", 24'h9FFFFF, 4'b0000, 24'h0, 1'b0);
        chk_dec("R5 ram home", 24'hC00000, 4'b0010, 24'h0, 1'b1);
        chk_dec("R8 gap miss", 24'hE00000, 4'b0000, 24'h0, 1'b0);
    endtask

    task automatic t_ram_both;
        set_mode(2'b01);
        chk_dec("R5 ram low 0", 24'h000000, 4'b0010, 24'h0, 1'b1);
        chk_dec("R5 ram low top", 24'h1FFFFF, 4'b0010, 24'h1FFFFF, 1'b1);
        chk_dec("R5 ram home top", 24'hDFFFFF, 4'b0010, 24'h1FFFFF, 1'b1);
        chk_dec("R4 rom home base", 24'h200000, 4'b0001, 24'h0, 1'b0);
        chk_dec("R4 rom home top", 24'h9FFFFF, 4'b0001, 24'h7FFFFF, 1'b0);
        chk_dec("R8 above rom miss", 24'hA00000, 4'b0000, 24'h0, 1'b0);
    endtask

    task automatic t_sfr_both;
        set_mode(2'b10);
        chk_dec("R6 sfr low 0", 24'h000000, 4'b0100, 24'h0, 1'b1);
        chk_dec("R6 sfr low top", 24'h07FFFF, 4'b0100, 24'h07FFFF, 1'b1);
        chk_dec("R8 after sfr low miss", 24'h080000, 4'b0000, 24'h0, 1'b0);
        chk_dec("R6 sfr home", 24'hF00004, 4'b0100, 24'h4, 1'b1);
        chk_dec("R6 sfr home top", 24'hF7FFFF, 4'b0100, 24'h07FFFF, 1'b1);
        chk_dec("R7 io base", 24'hF80000, 4'b1000, 24'h0, 1'b0);
        chk_dec("R7 io top", 24'hFFFFFF, 4'b1000, 24'h07FFFF, 1'b0);
        chk_dec("R4 rom home in sfr mode", 24'h300010, 4'b0001, 24'h100010, 1'b0);
    endtask

    task automatic t_waits;
        set_mode(2'b00);
        run_req("R10 rom wait3", 24'h000100, 4'd3, 4'd0, 3);
        run_req("R10 rom wait0", 24'h000100, 4'd0, 4'd0, 0);
        run_req("R10 rom wait15", 24'h000200, 4'd15, 4'd0, 15);
        run_req("R10 io wait5", 24'hF80010, 4'd9, 4'd5, 5);
        run_req("R11 ram fast", 24'hC00010, 4'd7, 4'd7, 0);
        run_req("R11 sfr fast", 24'hF00010, 4'd7, 4'd7, 0);
        run_req("R11 miss fast", 24'hA00000, 4'd7, 4'd7, 0);
    endtask

    task automatic t_abort;
        @(negedge clk);
        addr_i = 24'h000040; rom_wait_i = 4'd4; req_i = 1'b1;
        #5; chk("R12 first low", 32'(ready_o), 32'h0);
        @(negedge clk);
        #5; chk("R12 second low", 32'(ready_o), 32'h0);
        @(negedge clk);
        req_i = 1'b0;
        #5; chk("R12 dropped no ready", 32'(ready_o), 32'h0);
        run_req("R12 restart full wait", 24'h000040, 4'd4, 4'd0, 4);
    endtask

    initial begin : watchdog
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_mode_write();
        t_rom_low();
        t_ram_both();
        t_sfr_both();
        t_waits();
        t_abort();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule